// File: doc/BRIEF.md
# Backlight PWM Generator with Prescaler

The block drives one pulse-width-modulated backlight line from a raw reference clock. Software programs three values through a write-enable register port: a 16-bit divider, a 16-bit duty value and a prescale select bit. The output period is the divider times a prescale multiplier of either 16 or 128, counted in reference clock cycles. The high time is the duty value times the same multiplier.

Writes land in shadow registers. The counter works from an active copy of those registers, and the active copy is refreshed only when a period ends or while the generator is idle. This means a write never cuts a pulse short or stretches it. A divider of zero parks the generator with the output low. A duty value larger than the divider is clamped, so the output stays high.

Top module: `bl_pwm_gen`

## Requirements
- R1: A synchronous active-high reset clears the counter and all registers and drives `pwm_out` low. The output stays low after reset until software writes a nonzero divider.
- R2: With an active divider D > 0 and multiplier M, the output repeats every D*M reference clock cycles.
- R3: Control bit 0 (written with `wr_sel`=2) selects the multiplier: 0 selects 16 and 1 selects 128.
- R4: A duty value of 0 holds `pwm_out` low for the whole period.
- R5: A duty value equal to the divider holds `pwm_out` high continuously.
- R6: A duty value greater than the divider is clamped to the divider, so `pwm_out` stays high continuously.
- R7: A divider of 0 stops the counter and holds `pwm_out` low, whatever the duty value is.
- R8: New divider, duty and multiplier values take effect only at the end of the current period, or immediately when the generator is idle.
- R9: Each period starts with `pwm_out` high (for a nonzero duty). The output goes low once the in-period count reaches duty*M. `pwm_out` is registered and follows the counter state by one clock.
- R10: A write with `wr_en`=1 stores `wr_data` according to `wr_sel`: 0 writes the divider, 1 writes the duty value and 2 writes the control bits. A write with `wr_sel`=3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; the registers and the counter both run on it |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 divider, 1 duty, 2 control, 3 reserved |
| wr_data | input | 16 | Write data; for control, bit 0 is the multiplier select |
| pwm_out | output | 1 | Registered backlight PWM output |

## Verification
The hardest situation to reach is a write that arrives partway through a period. The bench must show that the running pulse finishes with its old high time and length, and that the new values appear only on the following period. To get there, the stimulus programs a running waveform and waits a number of cycles that is not a multiple of the period. It then rewrites the divider, the duty value and the multiplier in back-to-back cycles. The cycle-accurate reference model predicts the exact switchover cycle and compares against it on every clock.

// File: rtl/bl_pwm_pkg.sv
package bl_pwm_pkg;
  typedef enum logic [1:0] {
    SEL_DIV  = 2'd0,
    SEL_DUTY = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_RSVD = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/bl_pwm_regs.sv
module bl_pwm_regs
  import bl_pwm_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [DIV_W-1:0] wr_data,
  output logic [DIV_W-1:0] div_sh,
  output logic [DIV_W-1:0] duty_sh,
  output logic             mul_sh
);
  always_ff @(posedge clk) begin
    if (rst) begin
      div_sh  <= '0;
      duty_sh <= '0;
      mul_sh  <= 1'b0;
    end else if (wr_en) begin
      case (reg_sel_e'(wr_sel))
        SEL_DIV:  div_sh  <= wr_data;
        SEL_DUTY: duty_sh <= wr_data;
        SEL_CTRL: mul_sh  <= wr_data[0];
        default:  ;
      endcase
    end
  end

  // R10
  rsvd_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 2'd3) |=> ($stable(div_sh) && $stable(duty_sh) && $stable(mul_sh)));
  // R10
  no_write_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(div_sh) && $stable(duty_sh) && $stable(mul_sh)));
endmodule

// File: rtl/bl_pwm_timebase.sv
module bl_pwm_timebase #(
  parameter int DIV_W  = 16,
  parameter int MUL_LO = 16,
  parameter int MUL_HI = 128,
  localparam int CNT_W = DIV_W + $clog2(MUL_HI)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_sh,
  input  logic [DIV_W-1:0] duty_sh,
  input  logic             mul_sh,
  output logic [DIV_W-1:0] div_act,
  output logic [DIV_W-1:0] duty_act,
  output logic             mul_act,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] mul_val;
  logic [CNT_W-1:0] period;
  logic             idle;
  logic             wrap;

  assign mul_val = mul_act ? CNT_W'(MUL_HI) : CNT_W'(MUL_LO);
  assign period  = CNT_W'(div_act) * mul_val;
  assign idle    = (div_act == '0);
  assign wrap    = !idle && (cnt == period - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      div_act  <= '0;
      duty_act <= '0;
      mul_act  <= 1'b0;
      cnt      <= '0;
    end else begin
      if (idle || wrap) begin
        div_act  <= div_sh;
        duty_act <= duty_sh;
        mul_act  <= mul_sh;
        cnt      <= '0;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    !idle |-> (cnt < period));
  // R8
  mid_period_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!idle && !wrap) |=> ($stable(div_act) && $stable(duty_act) && $stable(mul_act)));
  // R7
  idle_count_chk: assert property (@(posedge clk) disable iff (rst)
    idle |=> (cnt == '0));
endmodule

// File: rtl/bl_pwm_compare.sv
module bl_pwm_compare #(
  parameter int DIV_W  = 16,
  parameter int MUL_LO = 16,
  parameter int MUL_HI = 128,
  localparam int CNT_W = DIV_W + $clog2(MUL_HI)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_act,
  input  logic [DIV_W-1:0] duty_act,
  input  logic             mul_act,
  input  logic [CNT_W-1:0] cnt,
  output logic             pwm_q
);
  logic [DIV_W-1:0] duty_eff;
  logic [CNT_W-1:0] high_len;

  assign duty_eff = (duty_act > div_act) ? div_act : duty_act;
  assign high_len = CNT_W'(duty_eff) * (mul_act ? CNT_W'(MUL_HI) : CNT_W'(MUL_LO));

  always_ff @(posedge clk) begin
    if (rst) pwm_q <= 1'b0;
    else     pwm_q <= (div_act != '0) && (cnt < high_len);
  end

  // R4
  zero_duty_low_chk: assert property (@(posedge clk) disable iff (rst)
    (duty_act == '0) |=> !pwm_q);
  // R5
  full_duty_high_chk: assert property (@(posedge clk) disable iff (rst)
    (div_act != '0 && duty_act == div_act) |=> pwm_q);
  // R6
  clamp_high_chk: assert property (@(posedge clk) disable iff (rst)
    (div_act != '0 && duty_act > div_act) |=> pwm_q);
  // R9
  period_start_high_chk: assert property (@(posedge clk) disable iff (rst)
    (div_act != '0 && duty_act != '0 && cnt == '0) |=> pwm_q);
  // R7
  idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    (div_act == '0) |=> !pwm_q);
endmodule

// File: rtl/bl_pwm_gen.sv
module bl_pwm_gen #(
  parameter int DIV_W  = 16,
  parameter int MUL_LO = 16,
  parameter int MUL_HI = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [DIV_W-1:0] wr_data,
  output logic             pwm_out
);
  localparam int CNT_W = DIV_W + $clog2(MUL_HI);

  logic [DIV_W-1:0] div_sh, duty_sh, div_act, duty_act;
  logic             mul_sh, mul_act;
  logic [CNT_W-1:0] cnt;

  bl_pwm_regs #(.DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .div_sh(div_sh), .duty_sh(duty_sh), .mul_sh(mul_sh)
  );

  bl_pwm_timebase #(.DIV_W(DIV_W), .MUL_LO(MUL_LO), .MUL_HI(MUL_HI)) u_tb (
    .clk(clk), .rst(rst), .div_sh(div_sh), .duty_sh(duty_sh), .mul_sh(mul_sh),
    .div_act(div_act), .duty_act(duty_act), .mul_act(mul_act), .cnt(cnt)
  );

  bl_pwm_compare #(.DIV_W(DIV_W), .MUL_LO(MUL_LO), .MUL_HI(MUL_HI)) u_cmp (
    .clk(clk), .rst(rst), .div_act(div_act), .duty_act(duty_act),
    .mul_act(mul_act), .cnt(cnt), .pwm_q(pwm_out)
  );

  // R1
  reset_low_chk: assert property (@(posedge clk) rst |=> !pwm_out);
endmodule

// File: tb/bl_pwm_gen_test.sv
`timescale 1ns/1ps
module bl_pwm_gen_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic        pwm_out;

  int checks = 0;
  int fails  = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  // behavioural reference state
  int sh_div, sh_duty, sh_mul, a_div, a_duty, a_mul, m_cnt;
  bit m_out;

  always #5 clk = ~clk;

  bl_pwm_gen uut (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
                  .wr_data(wr_data), .pwm_out(pwm_out));

  always @(posedge clk) begin
    int mul, per, eff;
    bit bound;
    if (rst) begin
      sh_div = 0; sh_duty = 0; sh_mul = 0;
      a_div = 0; a_duty = 0; a_mul = 0; m_cnt = 0; m_out = 0;
    end else begin
      mul = a_mul ? 128 : 16;
      per = a_div * mul;
      eff = (a_duty > a_div) ? a_div : a_duty;
      m_out = (a_div != 0) && (m_cnt < eff * mul);
      bound = (a_div == 0) || (m_cnt == per - 1);
      if (bound) begin
        a_div = sh_div; a_duty = sh_duty; a_mul = sh_mul; m_cnt = 0;
      end else m_cnt = m_cnt + 1;
      if (wr_en) begin
        case (wr_sel)
          2'd0: sh_div  = wr_data;
          2'd1: sh_duty = wr_data;
          2'd2: sh_mul  = wr_data[0];
          default: ;
        endcase
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (pwm_out !== m_out) begin
        fails++;
        $display("FAIL %s: pwm_out actual=%0b expected=%0b at %0t", cur_req, pwm_out, m_out, $time);
      end
    end
  end

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(input bit exp, input string req);
    checks++;
    if (pwm_out !== exp) begin
      fails++;
      $display("FAIL %s: pwm_out actual=%0b expected=%0b", req, pwm_out, exp);
    end
  endtask

  // measures spacing of two rising edges, compares with expected period
  task automatic check_period(input int exp, input string req);
    int t0 = -1;
    int n = 0;
    bit prev = pwm_out;
    int got = -1;
    while (n < 4 * exp + 10 && got < 0) begin
      @(negedge clk);
      n++;
      if (pwm_out && !prev) begin
        if (t0 < 0) t0 = n;
        else got = n - t0;
      end
      prev = pwm_out;
    end
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: period actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cur_req = "R1";
    expect_out(1'b0, "R1");
    run(20);
    expect_out(1'b0, "R1");

    cur_req = "R10";
    wr(2'd3, 16'h0004);
    run(10);
    expect_out(1'b0, "R10");

    cur_req = "R7";
    wr(2'd1, 16'd3);
    run(40);
    expect_out(1'b0, "R7");

    cur_req = "R2";
    wr(2'd1, 16'd1);
    wr(2'd0, 16'd4);
    run(5);
    check_period(64, "R2");
    cur_req = "R9";
    run(200);

    cur_req = "R3";
    wr(2'd2, 16'd1);
    run(70);
    check_period(512, "R3");
    wr(2'd2, 16'd0);
    run(600);

    cur_req = "R4";
    wr(2'd1, 16'd0);
    run(200);
    expect_out(1'b0, "R4");

    cur_req = "R5";
    wr(2'd1, 16'd4);
    run(200);
    expect_out(1'b1, "R5");

    cur_req = "R6";
    wr(2'd1, 16'd9);
    run(200);
    expect_out(1'b1, "R6");

    cur_req = "R8";
    wr(2'd1, 16'd2);
    wr(2'd0, 16'd3);
    run(150);
    run(17);
    wr(2'd0, 16'd2);
    wr(2'd1, 16'd1);
    wr(2'd2, 16'd1);
    run(900);
    wr(2'd0, 16'd0);
    run(30);
    expect_out(1'b0, "R7");

    cur_req = "R1";
    wr(2'd0, 16'd2);
    run(10);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    expect_out(1'b0, "R1");
    run(50);
    expect_out(1'b0, "R1");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule